// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a controller that runs command sequences on a 16-bit parallel NOR flash bus on behalf of a host. A host request selects one of three jobs: read the identification words and the protect flag of one sector, erase one sector, or program one 32-bit word as two halfwords. The sequencer writes the unlock cycles and the command code, performs the data accesses, polls status bit 7 until the device reports completion or a cycle-count limit runs out, and returns the device to read mode where the job requires it.

The host drives a one-cycle request with an opcode, a sector base address, a target halfword address and a 32-bit data word. When the job ends the block pulses `done` for one cycle together with a 2-bit result code; the identification words and the protect flag stay on their outputs until the next identification job. Every bus access, read or write, holds the strobes active for a fixed number of clocks and is followed by one recovery clock in which address and data stay unchanged.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every erase and program command, and the identification command, is preceded by the unlock pair: halfword 0x00AA written to address 0x5555, then 0x0055 written to address 0x2AAA.
- R2: Opcode 0 (identify) writes 0x0090 to 0x5555 after the unlock pair, reads address 0 into `mfr_id`, address 1 into `dev_id`, bit 0 of address `req_sector`+2 into `prot_flag`, then writes 0x00F0 to address 0.
- R3: Opcode 1 (erase) writes unlock, 0x0080 to 0x5555, unlock again, 0x0030 to `req_sector`, polls `req_sector` until bit 7 reads 1, then writes 0x00F0 to address 0.
- R4: Opcode 2 (program) writes `req_data[31:16]` to `req_addr` and `req_data[15:0]` to `req_addr`+1, each as unlock, 0x00A0 to 0x5555, then the data write, polling the target until its bit 7 equals bit 7 of the written halfword before the next half starts.
- R5: Before programming, both target halfwords are read; if for either one (current AND new) differs from new, the job ends with status 2 and no bus write is made.
- R6: If polling has lasted `POLL_LIMIT` clocks and the latest poll read still shows the device busy, the job ends with status 1 and no further bus write is made.
- R7: A job that completes normally ends with status 0; `done` is high for exactly one clock per job and `status` is never 3.
- R8: A request arriving while `busy` is high is ignored; a request in the same clock as `done` is accepted; opcode 3 is ignored and produces no bus access and no `done`.
- R9: During a write, `f_ce_n` and `f_we_n` are low for exactly `STROBE_CYC` clocks with `f_oe_n` high and `f_dq_oe` high; `f_addr` and `f_dout` do not change while the strobe is low nor in the clock it rises; during a read `f_oe_n` is low and `f_dq_oe` low.
- R10: After reset `busy` and `done` are low and all bus strobes are high; whenever the sequencer is idle the bus strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle job request |
| req_op | input | 2 | Job code: 0 identify, 1 erase, 2 program, 3 reserved |
| req_sector | input | AW | Sector base halfword address |
| req_addr | input | AW | Program target halfword address |
| req_data | input | 32 | Word to program |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job end pulse |
| status | output | 2 | 0 success, 1 timeout, 2 target not erased |
| mfr_id | output | 16 | Manufacturer word from the last identify |
| dev_id | output | 16 | Device word from the last identify |
| prot_flag | output | 1 | Protect bit of the sector in the last identify |
| f_addr | output | AW | Flash halfword address |
| f_dout | output | 16 | Data to the flash |
| f_din | input | 16 | Data from the flash |
| f_dq_oe | output | 1 | Drive enable for the data pins |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |

## Verification
The two functions that share a clock are the end of one job, signalled by `done`, and the acceptance of the next request, since the sequencer is already idle in the cycle it pulses `done`. The bench waits for `done`, drives the next request in that very cycle, and judges the second job by its complete bus write log and its own `done`. The opposite case, a request in the middle of an erase poll, is provoked the same way and must leave the write log and the identification outputs untouched.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

   typedef enum logic [1:0] {
      OP_IDENT = 2'd0,
      OP_ERASE = 2'd1,
      OP_PROG  = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      K_WR    = 3'd0,
      K_RD    = 3'd1,
      K_POLL  = 3'd2,
      K_CHECK = 3'd3,
      K_END   = 3'd4
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LOOK = 2'd1,
      S_BUS  = 2'd2
   } seq_st_e;

   typedef enum logic [1:0] {
      B_IDLE = 2'd0,
      B_ACT  = 2'd1,
      B_REC  = 2'd2
   } bus_ph_e;

   localparam logic [1:0] ST_OK    = 2'd0;
   localparam logic [1:0] ST_TMO   = 2'd1;
   localparam logic [1:0] ST_DIRTY = 2'd2;

   localparam logic [15:0] UNL_ADDR_A = 16'h5555;
   localparam logic [15:0] UNL_ADDR_B = 16'h2AAA;
   localparam logic [15:0] UNL_DATA_A = 16'h00AA;
   localparam logic [15:0] UNL_DATA_B = 16'h0055;
   localparam logic [15:0] CMD_ID     = 16'h0090;
   localparam logic [15:0] CMD_ERSET  = 16'h0080;
   localparam logic [15:0] CMD_SECER  = 16'h0030;
   localparam logic [15:0] CMD_PROG   = 16'h00A0;
   localparam logic [15:0] CMD_READ   = 16'h00F0;
   localparam logic [15:0] POLL_ONE   = 16'h0080;

endpackage

// File: rtl/nfs_bus_cycle.sv
module nfs_bus_cycle
   import nfs_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int STROBE_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          ack,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] f_addr,
   output logic [DW-1:0] f_dout,
   input  logic [DW-1:0] f_din,
   output logic          f_dq_oe,
   output logic          f_ce_n,
   output logic          f_we_n,
   output logic          f_oe_n
);

   localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);

   bus_ph_e        ph_q;
   logic [CW-1:0]  cnt_q;
   logic [AW-1:0]  a_q;
   logic [DW-1:0]  d_q;
   logic           wr_q;
   logic [DW-1:0]  rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= B_IDLE;
         cnt_q <= '0;
         a_q   <= '0;
         d_q   <= '0;
         wr_q  <= 1'b0;
         rd_q  <= '0;
      end else begin
         unique case (ph_q)
            B_IDLE: begin
               if (start) begin
                  a_q   <= addr;
                  d_q   <= wdata;
                  wr_q  <= wr;
                  cnt_q <= CW'(STROBE_CYC - 1);
                  ph_q  <= B_ACT;
               end
            end
            B_ACT: begin
               if (cnt_q == '0) begin
                  ph_q <= B_REC;
                  if (!wr_q) rd_q <= f_din;
               end else begin
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            B_REC:   ph_q <= B_IDLE;
            default: ph_q <= B_IDLE;
         endcase
      end
   end

   assign ack     = (ph_q == B_REC);
   assign rdata   = rd_q;
   assign f_addr  = a_q;
   assign f_dout  = d_q;
   assign f_ce_n  = (ph_q != B_ACT);
   assign f_we_n  = !((ph_q == B_ACT) && wr_q);
   assign f_oe_n  = !((ph_q == B_ACT) && !wr_q);
   assign f_dq_oe = wr_q && (ph_q != B_IDLE);

endmodule

// File: rtl/nfs_poll_timer.sv
module nfs_poll_timer #(
   parameter int POLL_LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int TW = $clog2(POLL_LIMIT + 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != TW'(POLL_LIMIT)) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

   assign expired = (cnt_q == TW'(POLL_LIMIT));

endmodule

// File: rtl/nfs_step_rom.sv
module nfs_step_rom
   import nfs_pkg::*;
#(
   parameter int AW = 16
) (
   input  op_e           op,
   input  logic [3:0]    step,
   input  logic          half,
   input  logic [AW-1:0] sector,
   input  logic [AW-1:0] target,
   input  logic [15:0]   word0,
   input  logic [15:0]   word1,
   output kind_e         kind,
   output logic [AW-1:0] s_addr,
   output logic [15:0]   s_data
);

   localparam logic [AW-1:0] UA = AW'(UNL_ADDR_A);
   localparam logic [AW-1:0] UB = AW'(UNL_ADDR_B);

   logic [AW-1:0] tgt_half;
   logic [15:0]   wd_half;

   assign tgt_half = half ? (target + AW'(1)) : target;
   assign wd_half  = half ? word1 : word0;

   always_comb begin
      kind   = K_END;
      s_addr = '0;
      s_data = '0;
      unique case (op)
         OP_IDENT: begin
            unique case (step)
               4'd0: begin kind = K_WR; s_addr = UA;            s_data = UNL_DATA_A; end
               4'd1: begin kind = K_WR; s_addr = UB;            s_data = UNL_DATA_B; end
               4'd2: begin kind = K_WR; s_addr = UA;            s_data = CMD_ID;     end
               4'd3: begin kind = K_RD; s_addr = '0;                                 end
               4'd4: begin kind = K_RD; s_addr = AW'(1);                             end
               4'd5: begin kind = K_RD; s_addr = sector + AW'(2);                    end
               4'd6: begin kind = K_WR; s_addr = '0;            s_data = CMD_READ;   end
               default: kind = K_END;
            endcase
         end
         OP_ERASE: begin
            unique case (step)
               4'd0: begin kind = K_WR;   s_addr = UA;     s_data = UNL_DATA_A; end
               4'd1: begin kind = K_WR;   s_addr = UB;     s_data = UNL_DATA_B; end
               4'd2: begin kind = K_WR;   s_addr = UA;     s_data = CMD_ERSET;  end
               4'd3: begin kind = K_WR;   s_addr = UA;     s_data = UNL_DATA_A; end
               4'd4: begin kind = K_WR;   s_addr = UB;     s_data = UNL_DATA_B; end
               4'd5: begin kind = K_WR;   s_addr = sector; s_data = CMD_SECER;  end
               4'd6: begin kind = K_POLL; s_addr = sector; s_data = POLL_ONE;   end
               4'd7: begin kind = K_WR;   s_addr = '0;     s_data = CMD_READ;   end
               default: kind = K_END;
            endcase
         end
         OP_PROG: begin
            unique case (step)
               4'd0: begin kind = K_RD;    s_addr = target;            end
               4'd1: begin kind = K_RD;    s_addr = target + AW'(1);   end
               4'd2: begin kind = K_CHECK;                             end
               4'd3: begin kind = K_WR;    s_addr = UA;       s_data = UNL_DATA_A; end
               4'd4: begin kind = K_WR;    s_addr = UB;       s_data = UNL_DATA_B; end
               4'd5: begin kind = K_WR;    s_addr = UA;       s_data = CMD_PROG;   end
               4'd6: begin kind = K_WR;    s_addr = tgt_half; s_data = wd_half;    end
               4'd7: begin kind = K_POLL;  s_addr = tgt_half; s_data = wd_half;    end
               default: kind = K_END;
            endcase
         end
         default: kind = K_END;
      endcase
   end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nfs_pkg::*;
#(
   parameter int AW         = 16,
   parameter int STROBE_CYC = 2,
   parameter int POLL_LIMIT = 4096,
   parameter bit HI_FIRST   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_sector,
   input  logic [AW-1:0] req_addr,
   input  logic [31:0]   req_data,
   output logic          busy,
   output logic          done,
   output logic [1:0]    status,
   output logic [15:0]   mfr_id,
   output logic [15:0]   dev_id,
   output logic          prot_flag,
   output logic [AW-1:0] f_addr,
   output logic [15:0]   f_dout,
   input  logic [15:0]   f_din,
   output logic          f_dq_oe,
   output logic          f_ce_n,
   output logic          f_we_n,
   output logic          f_oe_n
);

   if (AW < 16) begin : g_bad_aw
      $error("nor_cmd_seq: AW must cover the unlock addresses");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("nor_cmd_seq: STROBE_CYC must be at least 1");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("nor_cmd_seq: POLL_LIMIT must be at least 1");
   end

   seq_st_e       st_q;
   op_e           op_q;
   logic [AW-1:0] sec_q;
   logic [AW-1:0] adr_q;
   logic [31:0]   dat_q;
   logic [3:0]    step_q;
   logic          half_q;
   logic          done_q;
   logic [1:0]    stat_q;
   logic [15:0]   mfr_q;
   logic [15:0]   dev_q;
   logic          prot_q;
   logic [15:0]   cur0_q;
   logic [15:0]   cur1_q;

   logic [15:0]   word0;
   logic [15:0]   word1;
   kind_e         kind;
   logic [AW-1:0] s_addr;
   logic [15:0]   s_data;
   logic          bus_start;
   logic          bus_ack;
   logic [15:0]   bus_rdata;
   logic          tmo;
   logic          dirty;
   logic          poll_ok;

   // halfword placed at the lower address is chosen by the ordering option
   if (HI_FIRST) begin : g_hi_first
      assign word0 = dat_q[31:16];
      assign word1 = dat_q[15:0];
   end else begin : g_lo_first
      assign word0 = dat_q[15:0];
      assign word1 = dat_q[31:16];
   end

   nfs_step_rom #(.AW(AW)) u_rom (
      .op     (op_q),
      .step   (step_q),
      .half   (half_q),
      .sector (sec_q),
      .target (adr_q),
      .word0  (word0),
      .word1  (word1),
      .kind   (kind),
      .s_addr (s_addr),
      .s_data (s_data)
   );

   assign bus_start = (st_q == S_LOOK) &&
                      ((kind == K_WR) || (kind == K_RD) || (kind == K_POLL));

   nfs_bus_cycle #(.AW(AW), .DW(16), .STROBE_CYC(STROBE_CYC)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bus_start),
      .wr      (kind == K_WR),
      .addr    (s_addr),
      .wdata   (s_data),
      .ack     (bus_ack),
      .rdata   (bus_rdata),
      .f_addr  (f_addr),
      .f_dout  (f_dout),
      .f_din   (f_din),
      .f_dq_oe (f_dq_oe),
      .f_ce_n  (f_ce_n),
      .f_we_n  (f_we_n),
      .f_oe_n  (f_oe_n)
   );

   nfs_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     ((st_q != S_IDLE) && (kind == K_POLL)),
      .expired (tmo)
   );

   assign dirty   = ((cur0_q & word0) != word0) || ((cur1_q & word1) != word1);
   assign poll_ok = (bus_rdata[7] == s_data[7]);

   // sequencing of steps, halves and job end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         op_q   <= OP_IDENT;
         sec_q  <= '0;
         adr_q  <= '0;
         dat_q  <= '0;
         step_q <= '0;
         half_q <= 1'b0;
         done_q <= 1'b0;
         stat_q <= ST_OK;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (req_valid && (req_op != OP_RSVD)) begin
                  op_q   <= op_e'(req_op);
                  sec_q  <= req_sector;
                  adr_q  <= req_addr;
                  dat_q  <= req_data;
                  step_q <= '0;
                  half_q <= 1'b0;
                  st_q   <= S_LOOK;
               end
            end
            S_LOOK: begin
               unique case (kind)
                  K_CHECK: begin
                     if (dirty) begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                        stat_q <= ST_DIRTY;
                     end else begin
                        step_q <= step_q + 4'd1;
                     end
                  end
                  K_END: begin
                     if ((op_q == OP_PROG) && !half_q) begin
                        half_q <= 1'b1;
                        step_q <= 4'd3;
                     end else begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                        stat_q <= ST_OK;
                     end
                  end
                  default: st_q <= S_BUS;
               endcase
            end
            S_BUS: begin
               if (bus_ack) begin
                  if (kind != K_POLL) begin
                     step_q <= step_q + 4'd1;
                     st_q   <= S_LOOK;
                  end else if (poll_ok) begin
                     step_q <= step_q + 4'd1;
                     st_q   <= S_LOOK;
                  end else if (tmo) begin
                     st_q   <= S_IDLE;
                     done_q <= 1'b1;
                     stat_q <= ST_TMO;
                  end else begin
                     st_q   <= S_LOOK;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // storage of read results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mfr_q  <= '0;
         dev_q  <= '0;
         prot_q <= 1'b0;
         cur0_q <= '0;
         cur1_q <= '0;
      end else if ((st_q == S_BUS) && bus_ack && (kind == K_RD)) begin
         if (op_q == OP_IDENT) begin
            unique case (step_q)
               4'd3:    mfr_q  <= bus_rdata;
               4'd4:    dev_q  <= bus_rdata;
               4'd5:    prot_q <= bus_rdata[0];
               default: ;
            endcase
         end else if (step_q == 4'd0) begin
            cur0_q <= bus_rdata;
         end else begin
            cur1_q <= bus_rdata;
         end
      end
   end

   assign busy      = (st_q != S_IDLE);
   assign done      = done_q;
   assign status    = stat_q;
   assign mfr_id    = mfr_q;
   assign dev_id    = dev_q;
   assign prot_flag = prot_q;

endmodule

// File: rtl/nfs_seq_chk.sv
module nfs_seq_chk #(
   parameter int AW         = 16,
   parameter int STROBE_CYC = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_op,
   input logic          busy,
   input logic          done,
   input logic [1:0]    status,
   input logic [AW-1:0] f_addr,
   input logic [15:0]   f_dout,
   input logic          f_dq_oe,
   input logic          f_ce_n,
   input logic          f_we_n,
   input logic          f_oe_n
);

   logic [15:0] lo_cnt;
   logic        wrote;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         wrote  <= 1'b0;
      end else begin
         lo_cnt <= f_we_n ? 16'd0 : (lo_cnt + 16'd1);
         if (req_valid && !busy && (req_op != 2'd3)) wrote <= 1'b0;
         else if (!f_we_n)                           wrote <= 1'b1;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R7
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 2'd3));                                   // R7
   AST_REFUSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (status == 2'd2)) |-> !wrote);                       // R5
   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_we_n) |-> (lo_cnt == 16'(STROBE_CYC)));               // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_ce_n && $past(!f_ce_n)) |-> $stable(f_addr));             // R9
   AST_ADDR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_ce_n) |-> $stable(f_addr));                           // R9
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_we_n) |-> $stable(f_dout));                           // R9
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!f_we_n && !f_oe_n));                                       // R9
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !f_we_n |-> (f_dq_oe && !f_ce_n));                            // R9
   AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      !f_oe_n |-> (!f_dq_oe && !f_ce_n));                           // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (f_ce_n && f_we_n && f_oe_n));                      // R10

endmodule

bind nor_cmd_seq nfs_seq_chk #(.AW(AW), .STROBE_CYC(STROBE_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .busy      (busy),
   .done      (done),
   .status    (status),
   .f_addr    (f_addr),
   .f_dout    (f_dout),
   .f_dq_oe   (f_dq_oe),
   .f_ce_n    (f_ce_n),
   .f_we_n    (f_we_n),
   .f_oe_n    (f_oe_n)
);

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;

   localparam int AW     = 16;
   localparam int STROBE = 2;
   localparam int LIMIT  = 200;
   localparam logic [15:0] MFR_VAL  = 16'h00A7;
   localparam logic [15:0] DEV_VAL  = 16'h5B3C;
   localparam logic [15:0] PROT_SEC = 16'h0040;

   typedef struct packed {
      logic [1:0]  op;
      logic [15:0] sec;
      logic [15:0] adr;
      logic [31:0] dat;
      logic [15:0] bsy;
      logic [1:0]  st;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 16'h0040, 16'h0000, 32'h0000_0000, 16'd0, 2'd0},
      '{2'd0, 16'h0080, 16'h0000, 32'h0000_0000, 16'd0, 2'd0},
      '{2'd1, 16'h0080, 16'h0000, 32'h0000_0000, 16'd3, 2'd0},
      '{2'd2, 16'h0000, 16'h0010, 32'h1234_ABCD, 16'd2, 2'd0},
      '{2'd2, 16'h0000, 16'h0010, 32'hFFFF_0001, 16'd2, 2'd2},
      '{2'd2, 16'h0000, 16'h0020, 32'h0000_0000, 16'd0, 2'd0},
      '{2'd1, 16'h00C0, 16'h0000, 32'h0000_0000, 16'd0, 2'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_sector = '0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_data = '0;
   logic          busy, done, prot_flag;
   logic [1:0]    status;
   logic [15:0]   mfr_id, dev_id;
   logic [AW-1:0] f_addr;
   logic [15:0]   f_dout;
   logic [15:0]   f_din;
   logic          f_dq_oe, f_ce_n, f_we_n, f_oe_n;

   always #2.5 clk = ~clk;

   nor_cmd_seq #(.AW(AW), .STROBE_CYC(STROBE), .POLL_LIMIT(LIMIT), .HI_FIRST(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_sector(req_sector), .req_addr(req_addr), .req_data(req_data),
      .busy(busy), .done(done), .status(status), .mfr_id(mfr_id), .dev_id(dev_id),
      .prot_flag(prot_flag), .f_addr(f_addr), .f_dout(f_dout), .f_din(f_din),
      .f_dq_oe(f_dq_oe), .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
   );

   // ---------------- flash model and bus monitor ----------------
   logic [15:0] mem [0:255];
   logic        id_mode, arm, erasing, model_clr;
   logic [15:0] busy_left, cfg_busy, pend;
   logic        we_prev, oe_prev;
   logic [15:0] la [0:31];
   logic [15:0] ld [0:31];
   int          lcnt, ndone, wlo, width_err;

   always_comb begin
      if (id_mode) begin
         if (f_addr == 16'h0000)      f_din = MFR_VAL;
         else if (f_addr == 16'h0001) f_din = DEV_VAL;
         else                         f_din = {15'd0, f_addr == (PROT_SEC + 16'd2)};
      end else if (busy_left != 0) begin
         if (erasing) f_din = 16'h0000;
         else         f_din = {8'h00, ~pend[7], 7'h00};
      end else if (erasing) begin
         f_din = 16'hFFFF;
      end else begin
         f_din = mem[f_addr[7:0]];
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
   end

   always @(posedge clk) begin
      we_prev <= f_we_n;
      oe_prev <= f_oe_n;
      if (done) ndone <= ndone + 1;
      if (!f_we_n) wlo <= wlo + 1;
      else wlo <= 0;
      if (rst_n && f_we_n && !we_prev) begin
         if (wlo != STROBE) width_err <= width_err + 1;
         if (lcnt < 32) begin
            la[lcnt] <= f_addr;
            ld[lcnt] <= f_dout;
         end
         lcnt <= lcnt + 1;
         erasing <= 1'b0;
         if (arm) begin
            mem[f_addr[7:0]] <= f_dout;
            pend <= f_dout;
            busy_left <= cfg_busy;
            arm <= 1'b0;
         end else if (f_dout == 16'h00A0) arm <= 1'b1;
         else if (f_dout == 16'h0090) id_mode <= 1'b1;
         else if (f_dout == 16'h00F0) id_mode <= 1'b0;
         else if (f_dout == 16'h0030) begin
            erasing <= 1'b1;
            busy_left <= cfg_busy;
         end
      end
      if (rst_n && f_oe_n && !oe_prev && busy_left != 0) busy_left <= busy_left - 16'd1;
      if (model_clr) begin
         busy_left <= '0;
         erasing <= 1'b0;
         arm <= 1'b0;
         id_mode <= 1'b0;
      end
   end

   // ---------------- bench bookkeeping ----------------
   int checks = 0, errors = 0;
   logic [15:0] ea [0:31];
   logic [15:0] ed [0:31];
   int          ecnt;
   logic [1:0]  got_st;
   bit          got_done;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] a, input logic [15:0] d);
      ea[ecnt] = a;
      ed[ecnt] = d;
      ecnt++;
   endtask

   task automatic unlock();
      push(16'h5555, 16'h00AA);
      push(16'h2AAA, 16'h0055);
   endtask

   // expected write log, computed from R1..R6
   task automatic build_exp(input vec_t v);
      ecnt = 0;
      if (v.op == 2'd0) begin
         unlock(); push(16'h5555, 16'h0090); push(16'h0000, 16'h00F0);
      end else if (v.op == 2'd1) begin
         unlock(); push(16'h5555, 16'h0080);
         unlock(); push(v.sec, 16'h0030); push(16'h0000, 16'h00F0);
      end else if (v.op == 2'd2 && v.st != 2'd2) begin
         unlock(); push(16'h5555, 16'h00A0); push(v.adr, v.dat[31:16]);
         if (v.st == 2'd0) begin
            unlock(); push(16'h5555, 16'h00A0); push(v.adr + 16'd1, v.dat[15:0]);
         end
      end
   endtask

   task automatic cmp_writes(input string req);
      bit ok = (lcnt == ecnt);
      int bad = -1;
      for (int i = 0; i < ecnt && ok; i++)
         if (la[i] !== ea[i] || ld[i] !== ed[i]) begin ok = 0; bad = i; end
      if (bad >= 0) check(ok, req, {la[bad], ld[bad]}, {ea[bad], ed[bad]});
      else          check(ok, req, lcnt, ecnt);
   endtask

   // called at a falling edge; returns at the falling edge where done is high
   task automatic run_op(input vec_t v);
      lcnt = 0;
      cfg_busy = v.bsy;
      req_valid = 1'b1;
      req_op = v.op;
      req_sector = v.sec;
      req_addr = v.adr;
      req_data = v.dat;
      @(negedge clk);
      req_valid = 1'b0;
      got_done = 0;
      for (int c = 0; c < 3000; c++) begin
         if (done) begin got_done = 1; break; end
         @(negedge clk);
      end
      got_st = status;
      check(got_done, "R7 job ends with done", {31'd0, got_done}, 32'd1);
   endtask

   task automatic clear_model();
      @(negedge clk);
      model_clr = 1'b1;
      @(negedge clk);
      model_clr = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      vec_t v;
      logic [15:0] mfr_keep;
      model_clr = 1'b0; cfg_busy = '0; busy_left = '0; pend = '0;
      id_mode = 0; arm = 0; erasing = 0; we_prev = 1; oe_prev = 1;
      lcnt = 0; ndone = 0; wlo = 0; width_err = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!busy && !done && f_ce_n && f_we_n && f_oe_n && !f_dq_oe,
            "R10 reset state", {busy, done, f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 6'b001110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R7
      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         build_exp(v);
         run_op(v);
         check(got_st == v.st, "R7 status code", got_st, v.st);
         cmp_writes(v.op == 2'd0 ? "R2 identify writes" :
                    v.op == 2'd1 ? "R3 erase writes" :
                    v.st == 2'd2 ? "R5 refused program writes nothing" : "R4 program writes");
         if (v.op == 2'd0) begin
            check(mfr_id == MFR_VAL && dev_id == DEV_VAL, "R2 id words",
                  {mfr_id, dev_id}, {MFR_VAL, DEV_VAL});
            check(prot_flag == (v.sec == PROT_SEC), "R2 protect flag", prot_flag, v.sec == PROT_SEC);
         end
         if (v.op == 2'd0 || v.op == 2'd1)
            check(ecnt > 2 && la[0] == 16'h5555 && ld[1] == 16'h0055, "R1 unlock prefix",
                  {la[0], ld[1]}, {16'h5555, 16'h0055});
         if (v.op == 2'd2 && v.st == 2'd0)
            check(mem[v.adr[7:0]] == v.dat[31:16] && mem[v.adr[7:0] + 8'd1] == v.dat[15:0],
                  "R4 halves land in order", {mem[v.adr[7:0]], mem[v.adr[7:0] + 8'd1]}, v.dat);
         @(negedge clk);
      end

      // R6: poll never completes
      v = '{2'd2, 16'h0000, 16'h0030, 32'h0101_0202, 16'hFFFF, 2'd1};
      build_exp(v);
      run_op(v);
      check(got_st == 2'd1, "R6 timeout status", got_st, 2'd1);
      repeat (10) @(negedge clk);
      cmp_writes("R6 no write after timeout");
      clear_model();

      // R8: request in the done cycle is accepted
      v = VECS[5];
      build_exp(VECS[6]);
      run_op(v);
      run_op(VECS[6]);
      check(got_st == 2'd0, "R8 back-to-back status", got_st, 2'd0);
      cmp_writes("R8 request in done cycle accepted");

      // R8: request while busy is ignored
      @(negedge clk);
      mfr_keep = mfr_id;
      v = VECS[2];
      build_exp(v);
      ndone = 0;
      lcnt = 0;
      cfg_busy = 16'd6;
      req_valid = 1'b1; req_op = v.op; req_sector = v.sec; req_addr = '0; req_data = '0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (8) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_sector = 16'h0040;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (300) @(negedge clk);
      check(ndone == 1, "R8 one done for ignored request", ndone, 1);
      cmp_writes("R8 busy request leaves erase writes");
      check(mfr_id == mfr_keep, "R8 id outputs untouched", mfr_id, mfr_keep);

      // R8: reserved opcode
      lcnt = 0;
      ndone = 0;
      req_valid = 1'b1; req_op = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      check(!busy, "R8 reserved opcode stays idle", busy, 0);
      repeat (50) @(negedge clk);
      check(ndone == 0 && lcnt == 0, "R8 reserved opcode no activity", {ndone[15:0], lcnt[15:0]}, 0);

      // R9: strobe width seen on every write
      check(width_err == 0, "R9 write strobe width", width_err, 0);
      check(f_ce_n && f_we_n && f_oe_n, "R10 idle bus quiet", {f_ce_n, f_we_n, f_oe_n}, 3'b111);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule